// File: doc/BRIEF.md
# Iterative Radix-16 Multiply-Accumulate Unit

This block is a sequential multiplier that consumes one four-bit multiplier digit per clock. A single 48-bit accumulator holds both the growing partial sum, in its upper half, and the multiplier operand that has not been used yet, in its lower half. A load command puts the multiplier into the lower 24 bits, clears the upper 24 bits and programs how many steps follow. Each step command multiplies the lowest nibble of the accumulator by the 24-bit multiplicand that is presented in that cycle. The 28-bit result of that multiply is added to the upper half, and the whole register moves four places to the right.

A 16x16 multiply takes four steps, and the 48-bit register then holds the product shifted left by eight. A 24x24 multiply takes six steps, and the register then holds the full 48-bit product. A done flag marks the end of the programmed sequence. Step commands that arrive after it has risen are ignored until the next load. The unit is meant to sit beside an operand datapath that supplies the multiplicand in every step cycle.

Top module: `rmac_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the done flag. A step command after reset and before any load leaves the accumulator at zero.
- R2: A load sets the accumulator to {24 zero bits, multiplier} and clears done. A load in the same cycle as a step command takes precedence over the step.
- R3: One step uses digit d = acc[3:0]. It forms the 28-bit sum S = acc[47:24] + d * multiplicand and writes {S, acc[23:4]} into the accumulator on the same clock edge.
- R4: In a cycle with neither load nor step, the accumulator keeps its value.
- R5: The done flag rises on the cycle after the last programmed step, and not earlier. It stays high until the next load.
- R6: Step commands that arrive while done is high leave the accumulator unchanged.
- R7: With a step count of 4 and a multiplier below 2^16, the final accumulator equals (multiplier * multiplicand) << 8.
- R8: With a step count of 6, the final accumulator equals the full 48-bit product of the two 24-bit operands. This includes the operand values 0, 0xFFFFFF and 0x800000.
- R9: A load with a step count of 0 raises done on the next cycle, and the accumulator keeps the loaded value.
- R10: A step count above 6 is treated as 6.
- R11: The direct digit multiplier and the shift-add digit multiplier produce identical accumulator and done outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Initialise the accumulator and the step count |
| step_i | input | 1 | Perform one multiply-add-shift iteration |
| steps_i | input | 3 | Number of steps, sampled on load |
| mplier_i | input | 24 | Multiplier operand, sampled on load |
| mcand_i | input | 24 | Multiplicand for the current step |
| acc_o | output | 48 | Accumulator contents |
| done_o | output | 1 | All programmed steps performed |

## Verification
The bench elaborates two copies of the unit with the default 24-bit multiplicand and 4-bit digit. One copy uses the direct digit multiplier and the other uses the shift-add variant. Both copies run the same stimulus and are checked against the same expected values. The expected value is computed from the step count: the consumed multiplier digits times the multiplicand, aligned to the top of the register, plus the unconsumed multiplier bits. This covers four-step runs with 24-bit multipliers that leave bits unconsumed, idle gaps in the middle of a run, loads that interrupt a run, and step counts of zero and above the maximum.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

   typedef enum logic [0:0] {
      MUL_DIRECT   = 1'b0,
      MUL_SHIFTADD = 1'b1
   } mul_style_e;

   function automatic int steps_for(input int mcand_w, input int digit_w);
      return mcand_w / digit_w;
   endfunction

   function automatic int cnt_bits(input int max_steps);
      int b;
      b = 1;
      while ((1 << b) <= max_steps) b++;
      return b;
   endfunction

endpackage

// File: rtl/rmac_digit_mul.sv
module rmac_digit_mul #(
   parameter int                   MCAND_W   = 24,
   parameter int                   DIGIT_W   = 4,
   parameter rmac_pkg::mul_style_e MUL_STYLE = rmac_pkg::MUL_DIRECT,
   localparam int                  PROD_W    = MCAND_W + DIGIT_W
) (
   input  logic [DIGIT_W-1:0] digit_i,
   input  logic [MCAND_W-1:0] mcand_i,
   output logic [PROD_W-1:0]  prod_o
);

   generate
      if (MUL_STYLE == rmac_pkg::MUL_DIRECT) begin : g_direct
         always_comb prod_o = PROD_W'(digit_i) * PROD_W'(mcand_i);
      end else begin : g_shiftadd
         logic [PROD_W-1:0] part [DIGIT_W];
         for (genvar j = 0; j < DIGIT_W; j++) begin : g_part
            always_comb part[j] = digit_i[j] ? (PROD_W'(mcand_i) << j) : '0;
         end
         always_comb begin
            prod_o = '0;
            for (int k = 0; k < DIGIT_W; k++) prod_o = prod_o + part[k];
         end
      end
   endgenerate

endmodule

// File: rtl/rmac_seq.sv
module rmac_seq #(
   parameter int  MAX_STEPS = 6,
   localparam int CNT_W     = rmac_pkg::cnt_bits(MAX_STEPS)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] steps_i,
   output logic             step_en_o,
   output logic             done_o
);

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] steps_sat;

   always_comb begin
      steps_sat = (steps_i > CNT_W'(MAX_STEPS)) ? CNT_W'(MAX_STEPS) : steps_i;
      step_en_o = step_i && !load_i && (remain_q != '0);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         remain_q <= '0;
         done_o   <= 1'b0;
      end else if (load_i) begin
         remain_q <= steps_sat;
         done_o   <= (steps_sat == '0);
      end else if (step_en_o) begin
         remain_q <= remain_q - 1'b1;
         done_o   <= (remain_q == CNT_W'(1));
      end
   end

endmodule

// File: rtl/rmac_datapath.sv
module rmac_datapath #(
   parameter int                   MCAND_W   = 24,
   parameter int                   DIGIT_W   = 4,
   parameter rmac_pkg::mul_style_e MUL_STYLE = rmac_pkg::MUL_DIRECT,
   localparam int                  ACC_W     = 2 * MCAND_W,
   localparam int                  PROD_W    = MCAND_W + DIGIT_W
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               load_i,
   input  logic               step_en_i,
   input  logic [MCAND_W-1:0] mplier_i,
   input  logic [MCAND_W-1:0] mcand_i,
   output logic [ACC_W-1:0]   acc_o
);

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] sum;

   rmac_digit_mul #(
      .MCAND_W  (MCAND_W),
      .DIGIT_W  (DIGIT_W),
      .MUL_STYLE(MUL_STYLE)
   ) u_mul (
      .digit_i(acc_o[DIGIT_W-1:0]),
      .mcand_i(mcand_i),
      .prod_o (prod)
   );

   always_comb sum = PROD_W'(acc_o[ACC_W-1:MCAND_W]) + prod;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_o <= '0;
      end else if (load_i) begin
         acc_o <= {{MCAND_W{1'b0}}, mplier_i};
      end else if (step_en_i) begin
         acc_o <= {sum, acc_o[MCAND_W-1:DIGIT_W]};
      end
   end

endmodule

// File: rtl/rmac_unit.sv
module rmac_unit #(
   parameter int                   MCAND_W   = 24,
   parameter int                   DIGIT_W   = 4,
   parameter rmac_pkg::mul_style_e MUL_STYLE = rmac_pkg::MUL_DIRECT,
   localparam int                  ACC_W     = 2 * MCAND_W,
   localparam int                  MAX_STEPS = rmac_pkg::steps_for(MCAND_W, DIGIT_W),
   localparam int                  CNT_W     = rmac_pkg::cnt_bits(MAX_STEPS)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               load_i,
   input  logic               step_i,
   input  logic [CNT_W-1:0]   steps_i,
   input  logic [MCAND_W-1:0] mplier_i,
   input  logic [MCAND_W-1:0] mcand_i,
   output logic [ACC_W-1:0]   acc_o,
   output logic               done_o
);

   initial begin
      assert (DIGIT_W > 0 && MCAND_W % DIGIT_W == 0)
         else $error("rmac_unit: MCAND_W must be a multiple of DIGIT_W");
      assert (MCAND_W > DIGIT_W)
         else $error("rmac_unit: MCAND_W must exceed DIGIT_W");
   end

   logic step_en;

   rmac_seq #(
      .MAX_STEPS(MAX_STEPS)
   ) u_seq (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (load_i),
      .step_i   (step_i),
      .steps_i  (steps_i),
      .step_en_o(step_en),
      .done_o   (done_o)
   );

   rmac_datapath #(
      .MCAND_W  (MCAND_W),
      .DIGIT_W  (DIGIT_W),
      .MUL_STYLE(MUL_STYLE)
   ) u_dp (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (load_i),
      .step_en_i(step_en),
      .mplier_i (mplier_i),
      .mcand_i  (mcand_i),
      .acc_o    (acc_o)
   );

endmodule

// File: rtl/rmac_unit_chk.sv
module rmac_unit_chk #(
   parameter int  MCAND_W = 24,
   parameter int  DIGIT_W = 4,
   localparam int ACC_W   = 2 * MCAND_W
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               load_i,
   input logic               step_i,
   input logic [MCAND_W-1:0] mplier_i,
   input logic [ACC_W-1:0]   acc_o,
   input logic               done_o
);

   assert_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> (acc_o == {{MCAND_W{1'b0}}, $past(mplier_i)}) && !done_o || (done_o && acc_o == {{MCAND_W{1'b0}}, $past(mplier_i)}));

   assert_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !step_i) |=> $stable(acc_o));

   assert_shift_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && step_i) |=> ($stable(acc_o) || acc_o[MCAND_W-DIGIT_W-1:0] == $past(acc_o[MCAND_W-1:DIGIT_W])));

   assert_done_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && !load_i) |=> done_o);

   assert_ignore_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && !load_i) |=> $stable(acc_o));

endmodule

bind rmac_unit rmac_unit_chk #(
   .MCAND_W(MCAND_W),
   .DIGIT_W(DIGIT_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .load_i  (load_i),
   .step_i  (step_i),
   .mplier_i(mplier_i),
   .acc_o   (acc_o),
   .done_o  (done_o)
);

// File: tb/rmac_unit_tb.sv
module rmac_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   // {multiplier, multiplicand, step count}
   localparam logic [50:0] VEC [NVEC] = '{
      {24'h000000, 24'h000000, 3'd4},
      {24'h00FFFF, 24'h00FFFF, 3'd4},
      {24'h000001, 24'h00FFFF, 3'd4},
      {24'h001234, 24'h00ABCD, 3'd4},
      {24'h008000, 24'h008000, 3'd4},
      {24'h5A1234, 24'h00ABCD, 3'd4},
      {24'hFFFFFF, 24'hFFFFFF, 3'd6},
      {24'h800000, 24'h800000, 3'd6},
      {24'h800000, 24'hFFFFFF, 3'd6},
      {24'h123456, 24'h654321, 3'd6},
      {24'h000000, 24'hFFFFFF, 3'd6},
      {24'hABCDEF, 24'h000001, 3'd6}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load = 1'b0;
   logic        step = 1'b0;
   logic [2:0]  steps = '0;
   logic [23:0] mplier = '0;
   logic [23:0] mcand = '0;
   logic [47:0] acc_a, acc_b;
   logic        done_a, done_b;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rmac_unit #(.MUL_STYLE(rmac_pkg::MUL_DIRECT)) u_dut (
      .clk_i(clk), .rst_i(rst), .load_i(load), .step_i(step), .steps_i(steps),
      .mplier_i(mplier), .mcand_i(mcand), .acc_o(acc_a), .done_o(done_a));

   rmac_unit #(.MUL_STYLE(rmac_pkg::MUL_SHIFTADD)) u_dut_alt (
      .clk_i(clk), .rst_i(rst), .load_i(load), .step_i(step), .steps_i(steps),
      .mplier_i(mplier), .mcand_i(mcand), .acc_o(acc_b), .done_o(done_b));

   function automatic logic [47:0] expect_acc(input logic [23:0] a, input logic [23:0] m,
                                              input int n);
      logic [63:0] mask, e;
      mask = (64'd1 << (4 * n)) - 64'd1;
      e = ((64'(a) & mask) * 64'(m)) << (24 - 4 * n);
      e = e + (64'(a) >> (4 * n));
      return e[47:0];
   endfunction

   task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_both(input string req, input logic [47:0] exp_acc, input logic exp_done);
      chk(req, acc_a, exp_acc);
      chk({req, " R11 alt"}, acc_b, exp_acc);
      chk({req, " done"}, 48'(done_a), 48'(exp_done));
      chk({req, " done R11 alt"}, 48'(done_b), 48'(exp_done));
   endtask

   task automatic run(input logic [23:0] a, input logic [23:0] m, input logic [2:0] n_in,
                      input bit gap, input string req);
      int n;
      logic [47:0] held;
      n = (n_in > 3'd6) ? 6 : int'(n_in);
      @(negedge clk);
      load = 1'b1; mplier = a; steps = n_in; step = 1'b0;
      @(negedge clk);
      load = 1'b0;
      chk_both({req, " R2 load"}, {24'h0, a}, n == 0);
      step = 1'b1; mcand = m;
      for (int i = 0; i < n; i++) begin
         if (gap && i == 2) begin
            step = 1'b0;
            held = acc_a;
            @(negedge clk);
            chk_both("R4 idle gap", held, 1'b0);
            step = 1'b1;
         end
         @(negedge clk);
         if (i < n - 1) begin
            chk({req, " R5 early done"}, 48'(done_a), 48'd0);
            chk({req, " R5 early done R11 alt"}, 48'(done_b), 48'd0);
         end
      end
      step = 1'b0;
      chk_both(req, expect_acc(a, m, n), 1'b1);
      step = 1'b1; mcand = 24'h5A5A5A;
      @(negedge clk);
      step = 1'b0;
      chk_both("R6 step after done", expect_acc(a, m, n), 1'b1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk_both("R1 reset state", 48'h0, 1'b0);
      step = 1'b1; mcand = 24'hFFFFFF;
      @(negedge clk);
      @(negedge clk);
      step = 1'b0;
      chk_both("R1 step before load", 48'h0, 1'b0);

      for (int v = 0; v < NVEC; v++) begin
         run(VEC[v][50:27], VEC[v][26:3], VEC[v][2:0], v == 3 || v == 9,
             (VEC[v][2:0] == 3'd4) ? "R7 R3 16x16" : "R8 R3 24x24");
      end

      run(24'h00C0DE, 24'h00BEEF, 3'd0, 1'b0, "R9 zero count");
      run(24'h987654, 24'hFEDCBA, 3'd7, 1'b0, "R10 count clamp");

      // load wins over a simultaneous step, mid-run
      @(negedge clk);
      load = 1'b1; mplier = 24'h00F00F; steps = 3'd4;
      @(negedge clk);
      load = 1'b0; step = 1'b1; mcand = 24'h001111;
      @(negedge clk);
      load = 1'b1; mplier = 24'h000777; steps = 3'd4;
      @(negedge clk);
      load = 1'b0; step = 1'b0;
      chk_both("R2 load over step", {24'h0, 24'h000777}, 1'b0);

      // restore with reset mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_both("R1 reset mid-run", 48'h0, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule